// File: doc/BRIEF.md
# Host/Default Mode Watchdog Controller

This block decides whether a register-programmed controller is being supervised by a host or is running on its own. After power-on it sits in default (autonomous) mode, with the watchdog treated as already expired. Any write from the bus moves it to host mode. In host mode a programmable watchdog counts prescaled ticks. If the host fails to kick the watchdog in time, the block falls back to default mode. It then asks the register file to reload its defaults, asks the input stage to run source detection again, and raises a one-cycle fault request.

The block sees only strobes and fields. A register-write strobe, a kick strobe (a 1 written to the self-clearing kick bit), a register-reset command strobe and the stored 2-bit timeout field come in. A mode flag, the kick bit readback and three one-cycle requests go out. Bus decoding, the register storage and the analog side belong to other blocks. The timeout is counted in units of `BASE_TICKS` ticks so that simulation can use a short scale. Kicks closer together than `KICK_GAP_CYC` clocks are refused. That parameter must be at least 2.

Top module: `hwd_ctrl`

## Requirements
- R1: After reset, `dflt_mode_o` is 1 and `kick_rb_o`, `restore_dflt_o`, `force_det_o` and `wd_fault_o` are 0.
- R2: A clock edge with any of `reg_wr_i`, `kick_i` or `reg_rst_i` high sets `dflt_mode_o` to 0 from the next cycle, unless an expiry happens on the same edge.
- R3: An accepted kick restarts the watchdog count from zero. `kick_rb_o` reads 1 for exactly one cycle after the kick and 0 afterwards.
- R4: A kick arriving fewer than `KICK_GAP_CYC` clocks after the last accepted kick is refused. It neither restarts the count nor raises `kick_rb_o`.
- R5: `tmo_sel_i` = 2'b00 disables the watchdog. In host mode, any number of ticks then leaves the block in host mode with no request raised.
- R6: `tmo_sel_i` values 2'b01, 2'b10 and 2'b11 give timeouts of 1x, 2x and 4x `BASE_TICKS` ticks. Expiry happens on the tick that reaches that count after the last restart.
- R7: On expiry, from the next cycle `dflt_mode_o` is 1, and `restore_dflt_o`, `force_det_o` and `wd_fault_o` are each high for exactly one cycle.
- R8: Setting `tmo_sel_i` to 2'b00 for at least one clock and then to a nonzero value restarts the count from zero with the new period.
- R9: `reg_rst_i` pulses `restore_dflt_o` for one cycle and restarts the count. It leaves the block in host mode and raises neither `force_det_o` nor `wd_fault_o`.
- R10: An accepted kick on the same edge as the final tick prevents the expiry. A plain register write on that edge does not prevent it.
- R11: In default mode, ticks never produce an expiry or any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled time-base tick, one clock wide |
| reg_wr_i | input | 1 | Strobe: a bus write to any register |
| kick_i | input | 1 | Strobe: a 1 written to the kick bit |
| reg_rst_i | input | 1 | Strobe: register-reset command |
| tmo_sel_i | input | 2 | Stored timeout code (00 off, 01/10/11 = 1x/2x/4x) |
| dflt_mode_o | output | 1 | 1 = default (autonomous) mode, 0 = host mode |
| kick_rb_o | output | 1 | Readback of the self-clearing kick bit |
| restore_dflt_o | output | 1 | One-cycle request to reload register defaults |
| force_det_o | output | 1 | One-cycle request for forced input-source detection |
| wd_fault_o | output | 1 | One-cycle watchdog fault request |

## Verification
The embedded properties hold on every cycle. They cover the following:
- The request pulses never last more than one cycle.
- Each entry into default mode carries both the fault and the re-detection requests.
- A register-reset restore leaves the block in host mode.
- The count is cleared whenever the watchdog is idle.
- Kick readback self-clears, and the kick lockout holds.

Only the bench scenarios can show that each timeout code expires on exactly the right tick, and that a 00-then-nonzero rewrite restarts from zero. The same applies to the two same-edge races: a kick against the final tick, and a write against the final tick.

// File: rtl/hwd_pkg.sv
package hwd_pkg;

  typedef enum logic [1:0] {
    TMO_OFF = 2'b00,
    TMO_X1  = 2'b01,
    TMO_X2  = 2'b10,
    TMO_X4  = 2'b11
  } tmo_e;

  typedef struct packed {
    logic restore;
    logic force_det;
    logic fault;
  } wd_evt_t;

  // ticks to expiry for a timeout code, 0 when disabled
  function automatic int unsigned tmo_ticks(input logic [1:0] code, input int unsigned base);
    case (tmo_e'(code))
      TMO_X1:  return base;
      TMO_X2:  return base * 2;
      TMO_X4:  return base * 4;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/hwd_kick_guard.sv
module hwd_kick_guard #(
  parameter int unsigned GAP_CYC = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic kick_ok_o,
  output logic kick_rb_o
);
  localparam int unsigned GAP_W = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC + 1);

  logic [GAP_W-1:0] gap_q;
  logic             rb_q;

  assign kick_ok_o = kick_i && (gap_q == '0);
  assign kick_rb_o = rb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
      rb_q  <= 1'b0;
    end else begin
      rb_q <= kick_ok_o;
      if (kick_ok_o)          gap_q <= GAP_W'(GAP_CYC - 1);
      else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
    end
  end

  generate
    if (GAP_CYC >= 2) begin : g_chk
      p_kick_selfclear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rb_q |=> !rb_q);
      p_gap_lockout_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gap_q != '0) |=> !rb_q);
    end
  endgenerate

endmodule

// File: rtl/hwd_tick_counter.sv
module hwd_tick_counter #(
  parameter int unsigned MAX_TICKS = 160,
  localparam int unsigned CNT_W    = $clog2(MAX_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  // >= covers a period shortened while counting
  assign expire_o = run_i && !restart_i && tick_i && (cnt_inc >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (restart_i || !run_i)  cnt_q <= '0;
    else if (expire_o)             cnt_q <= '0;
    else if (tick_i)               cnt_q <= cnt_inc[CNT_W-1:0];
  end

  p_idle_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
  p_cnt_in_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(MAX_TICKS));

endmodule

// File: rtl/hwd_mode_fsm.sv
module hwd_mode_fsm
  import hwd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_wr_i,
  input  logic reg_rst_i,
  input  logic expire_i,
  output logic dflt_o,
  output wd_evt_t evt_o
);
  logic    dflt_q;
  wd_evt_t evt_q;

  assign dflt_o = dflt_q;
  assign evt_o  = evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dflt_q <= 1'b1;  // power-up counts as expired
      evt_q  <= '0;
    end else begin
      if (expire_i)        dflt_q <= 1'b1;
      else if (host_wr_i)  dflt_q <= 1'b0;
      evt_q.restore   <= expire_i || reg_rst_i;
      evt_q.force_det <= expire_i;
      evt_q.fault     <= expire_i;
    end
  end

  p_fault_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q.fault |=> !evt_q.fault);
  p_enter_dflt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dflt_q) |-> (evt_q.fault && evt_q.force_det && evt_q.restore));
  p_regrst_host_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q.restore && !evt_q.fault) |-> !dflt_q);

endmodule

// File: rtl/hwd_ctrl.sv
module hwd_ctrl
  import hwd_pkg::*;
#(
  parameter int unsigned BASE_TICKS   = 40,
  parameter int unsigned KICK_GAP_CYC = 2500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       reg_wr_i,
  input  logic       kick_i,
  input  logic       reg_rst_i,
  input  logic [1:0] tmo_sel_i,
  output logic       dflt_mode_o,
  output logic       kick_rb_o,
  output logic       restore_dflt_o,
  output logic       force_det_o,
  output logic       wd_fault_o
);
  localparam int unsigned MAX_TICKS = BASE_TICKS * 4;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  logic             kick_ok, host_wr, run, restart, expire, dflt;
  logic [CNT_W-1:0] limit;
  wd_evt_t          evt;

  assign host_wr = reg_wr_i || kick_i || reg_rst_i;
  assign run     = !dflt && (tmo_sel_i != TMO_OFF);
  assign restart = kick_ok || reg_rst_i || (dflt && host_wr);
  assign limit   = CNT_W'(tmo_ticks(tmo_sel_i, BASE_TICKS));

  hwd_kick_guard #(.GAP_CYC(KICK_GAP_CYC)) u_kick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kick_i    (kick_i),
    .kick_ok_o (kick_ok),
    .kick_rb_o (kick_rb_o)
  );

  hwd_tick_counter #(.MAX_TICKS(MAX_TICKS)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (restart),
    .tick_i    (tick_i),
    .limit_i   (limit),
    .expire_o  (expire)
  );

  hwd_mode_fsm u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .host_wr_i (host_wr),
    .reg_rst_i (reg_rst_i),
    .expire_i  (expire),
    .dflt_o    (dflt),
    .evt_o     (evt)
  );

  assign dflt_mode_o    = dflt;
  assign restore_dflt_o = evt.restore;
  assign force_det_o    = evt.force_det;
  assign wd_fault_o     = evt.fault;

  p_no_count_dflt_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dflt |-> !expire);
  p_off_no_expire_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_sel_i == TMO_OFF) |-> !expire);

endmodule

// File: tb/hwd_ctrl_tb.sv
`timescale 1ns/1ps
module hwd_ctrl_tb;
  localparam int unsigned BASE = 4;
  localparam int unsigned GAP  = 8;

  typedef struct packed {
    logic [1:0] code;
    logic [7:0] nticks;
    logic       expect_exp;
  } vec_t;

  // R6 / R5 table: code, ticks applied, expiry expected on last tick
  localparam vec_t VECS [4] = '{
    '{code: 2'b01, nticks: 8'd4,  expect_exp: 1'b1},
    '{code: 2'b10, nticks: 8'd8,  expect_exp: 1'b1},
    '{code: 2'b11, nticks: 8'd16, expect_exp: 1'b1},
    '{code: 2'b00, nticks: 8'd40, expect_exp: 1'b0}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tick_i = 1'b0, reg_wr_i = 1'b0, kick_i = 1'b0, reg_rst_i = 1'b0;
  logic [1:0] tmo_sel_i = 2'b01;
  logic dflt_mode_o, kick_rb_o, restore_dflt_o, force_det_o, wd_fault_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  hwd_ctrl #(.BASE_TICKS(BASE), .KICK_GAP_CYC(GAP)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .reg_wr_i(reg_wr_i),
    .kick_i(kick_i), .reg_rst_i(reg_rst_i), .tmo_sel_i(tmo_sel_i),
    .dflt_mode_o(dflt_mode_o), .kick_rb_o(kick_rb_o), .restore_dflt_o(restore_dflt_o),
    .force_det_o(force_det_o), .wd_fault_o(wd_fault_o)
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one clock with the given strobes; outputs of that edge visible on return
  task automatic step(input bit t, input bit w, input bit k, input bit r);
    tick_i = t; reg_wr_i = w; kick_i = k; reg_rst_i = r;
    @(negedge clk_i);
    tick_i = 0; reg_wr_i = 0; kick_i = 0; reg_rst_i = 0;
  endtask

  task automatic ticks_quiet(input int n, input string req);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      step(1, 0, 0, 0);
      if (wd_fault_o || force_det_o || dflt_mode_o) bad = 1;
    end
    chk(bad, 0, req, "no expiry before period end");
  endtask

  task automatic chk_expired(input string req);
    chk(wd_fault_o, 1, req, "fault pulse");
    chk(force_det_o, 1, req, "detect pulse");
    chk(restore_dflt_o, 1, req, "restore pulse");
    chk(dflt_mode_o, 1, req, "back to default");
    step(0, 0, 0, 0);
    chk(wd_fault_o | force_det_o | restore_dflt_o, 0, "R7", "pulses one cycle");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(dflt_mode_o, 1, "R1", "default after reset");
    chk(kick_rb_o | restore_dflt_o | force_det_o | wd_fault_o, 0, "R1", "outputs idle");

    // R11: ticks in default mode do nothing
    begin
      bit any = 0;
      for (int i = 0; i < 20; i++) begin
        step(1, 0, 0, 0);
        if (wd_fault_o || force_det_o || restore_dflt_o) any = 1;
      end
      chk(any, 0, "R11", "no request in default mode");
      chk(dflt_mode_o, 1, "R11", "still default");
    end

    // R2: plain write enters host mode
    step(0, 1, 0, 0);
    chk(dflt_mode_o, 0, "R2", "write leaves default");

    // R6 / R5 table
    foreach (VECS[v]) begin
      tmo_sel_i = VECS[v].code;
      step(0, 1, 0, 0);
      ticks_quiet(int'(VECS[v].nticks) - 1, "R6");
      step(1, 0, 0, 0);
      if (VECS[v].expect_exp) chk_expired("R6");
      else begin
        chk(wd_fault_o, 0, "R5", "disabled no fault");
        chk(dflt_mode_o, 0, "R5", "disabled stays host");
      end
    end

    // R8: 00 then nonzero restarts from zero
    tmo_sel_i = 2'b10;
    ticks_quiet(5, "R8");
    tmo_sel_i = 2'b00;
    step(0, 0, 0, 0);
    tmo_sel_i = 2'b01;
    ticks_quiet(3, "R8");
    step(1, 0, 0, 0);
    chk_expired("R8");

    // R2/R3: kick from default mode
    step(0, 0, 1, 0);
    chk(dflt_mode_o, 0, "R2", "kick leaves default");
    chk(kick_rb_o, 1, "R3", "kick readback high");
    step(0, 0, 0, 0);
    chk(kick_rb_o, 0, "R3", "kick bit self-clears");

    // R3: kick restarts count
    ticks_quiet(3, "R3");
    repeat (GAP + 2) step(0, 0, 0, 0);
    step(0, 0, 1, 0);
    ticks_quiet(3, "R3");
    step(1, 0, 0, 0);
    chk_expired("R3");

    // R4: early kick refused
    step(0, 1, 0, 0);
    repeat (GAP + 2) step(0, 0, 0, 0);
    step(0, 0, 1, 0);
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    step(0, 0, 1, 0);
    chk(kick_rb_o, 0, "R4", "early kick no readback");
    step(1, 0, 0, 0);
    chk(wd_fault_o, 0, "R4", "third tick quiet");
    step(1, 0, 0, 0);
    chk_expired("R4");

    // R9: register reset keeps host mode, restarts count
    step(0, 1, 0, 0);
    ticks_quiet(3, "R9");
    step(0, 0, 0, 1);
    chk(restore_dflt_o, 1, "R9", "restore pulse");
    chk(force_det_o | wd_fault_o, 0, "R9", "no detect or fault");
    chk(dflt_mode_o, 0, "R9", "stays host");
    ticks_quiet(3, "R9");
    step(1, 0, 0, 0);
    chk_expired("R9");

    // R10: same-edge races
    step(0, 1, 0, 0);
    repeat (GAP + 2) step(0, 0, 0, 0);
    ticks_quiet(3, "R10");
    step(1, 0, 1, 0);
    chk(wd_fault_o, 0, "R10", "kick beats final tick");
    chk(kick_rb_o, 1, "R10", "kick accepted");
    chk(dflt_mode_o, 0, "R10", "host kept");
    ticks_quiet(3, "R10");
    step(1, 1, 0, 0);
    chk(wd_fault_o, 1, "R10", "write does not save");
    chk(dflt_mode_o, 1, "R10", "default after race");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule